// File: doc/BRIEF.md
# Block-Edge Row Filter Sequencer

This controller applies a narrow four-tap smoothing filter across one vertical block boundary held in a byte-addressed pixel memory. A descriptor gives the byte offset of the first pixel to the right of the boundary in row 0, together with three 8-bit thresholds. The thresholds are the edge limit, the interior limit and the high-variance limit. A row stride is supplied alongside the descriptor. Once the descriptor is accepted, the sequencer visits eight rows in turn. For each row it fetches the eight pixels that straddle the boundary, one byte per cycle, and hands them to an instantiated filter datapath. It then stores back only the pixels that the datapath marks as modified.

Address generation is contract-checked. If the offset is below 4, the first fetch would wrap below address zero. If the stride is below 4, the write windows of neighbouring rows would overlap. In either case the descriptor is refused with an error flag and no memory traffic. The memory port is synchronous, one byte wide, and returns read data one cycle after the request.

Top module: `edge_row_seq`

## Requirements
- R1: `desc_ready` is 1 only while idle. A descriptor is taken on a clock edge where `desc_valid` and `desc_ready` are both 1. While an edge is in progress, `desc_ready` stays 0. While idle, no memory access and no `done` occur.
- R2: If `desc_offset` < 4 or `row_stride` < 4, the block issues no memory access. In the cycle after acceptance it asserts `done` with `err` = 1. `err` then holds until the next descriptor is accepted.
- R3: A valid edge covers rows r = 0..7 with row base b = offset + r·stride. Each row begins with eight reads, one per cycle, at addresses b-4 up to b+3 in ascending order. These bytes are the pixels p3,p2,p1,p0,q0,q1,q2,q3.
- R4: `mem_rdata` is taken one cycle after its read request. Each row's eight reads are followed by exactly three cycles with no access. Then come the row's writes, and then one further idle cycle before the next row's reads.
- R5: The write set of a row is chosen by the filter decision. If the filter mask fails, there are no writes. Under high variance, b-1 and b are written. Otherwise b-2, b-1, b and b+1 are written. Each row therefore writes 0, 2 or 4 bytes.
- R6: The written values follow the reference filter. The mask passes when every neighbour difference within p3..p0 and within q0..q3 is at most the interior limit, and 2·|p0-q0| + (|p1-q1|>>1) is at most the edge limit. High variance holds when |p1-p0| or |q1-q0| exceeds the high-variance limit. The filter term is saturated to [-128,127]. The outputs are p0+f2 and q0-f1, plus p1+fp and q1-fp when variance is low. All outputs are clipped to [0,255].
- R7: Writes within a row are issued one per cycle, in ascending address order. A read and a write never occur in the same cycle.
- R8: After the last row, `done` is 1 for exactly one cycle, with `err` = 0 for a valid edge. The block then returns to idle.
- R9: After an edge completes, every memory byte outside the eight per-row write windows keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Sequencer idle, descriptor can be taken |
| desc_offset | input | AW | Byte address of q0 in row 0 |
| desc_elim | input | TW | Edge-difference limit |
| desc_ilim | input | TW | Interior-difference limit |
| desc_hlim | input | TW | High-variance limit |
| row_stride | input | AW | Byte distance between rows |
| mem_rd_en | output | 1 | Read request |
| mem_wr_en | output | 1 | Write request |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last descriptor broke the address contract |

## Verification
The bound checker watches, every cycle, the port-level orderings:
- read and write never coincide;
- reads within a row run at consecutive addresses;
- writes within a row rise in address;
- `done` lasts one cycle;
- an idle or erroneous sequencer stays off the memory port.

Some behaviour only the bench scenarios can show. This covers:
- which row base each access uses;
- whether a row writes 0, 2 or 4 bytes;
- the exact filtered values, including saturation at both ends;
- correct reuse of bytes already rewritten by the previous row when the stride is only 4;
- the absence of stray changes anywhere in memory.

// File: rtl/erf_pkg.sv
// Shared constants and the sequencer state type.
// Assumes an 8-bit pixel and a fixed eight-pixel fetch window per row.
package erf_pkg;
    localparam int PIX_W   = 8;   // bits per pixel
    localparam int TAPS    = 8;   // pixels fetched per row
    localparam int HALF    = TAPS / 2;
    localparam int WWIN    = 4;   // widest write window per row
    localparam int CW      = 12;  // internal arithmetic width

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_READ   = 3'd1,
        S_FILTER = 3'd2,
        S_WRITE  = 3'd3,
        S_NEXT   = 3'd4,
        S_DONE   = 3'd5
    } seq_state_t;
endpackage

// File: rtl/erf_addr.sv
// Row-base generator with address contract check.
// Loads the descriptor offset as row 0 base and adds the stride per step.
// Assumes the caller keeps offset + 7*stride + 3 inside the address space.
module erf_addr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] offset_in,
    input  logic [AW-1:0] stride_in,
    input  logic [AW-1:0] stride_q,
    output logic [AW-1:0] base,
    output logic          contract_ok
);
    localparam logic [AW-1:0] MIN_GAP = AW'(erf_pkg::HALF);

    // Contract: first fetch must not wrap, row write windows must not overlap.
    always_comb contract_ok = (offset_in >= MIN_GAP) && (stride_in >= MIN_GAP);

    // Base register: load row 0, advance one stride per row.
    always_ff @(posedge clk) begin
        if (!rst_n)    base <= '0;
        else if (load) base <= offset_in;
        else if (step) base <= base + stride_q;
    end
endmodule

// File: rtl/erf_win.sv
// Eight-byte capture window: shifts each returned byte in from the top.
// After eight captures slot 0 holds the lowest address (p3), slot 7 the highest (q3).
module erf_win (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      cap,
    input  logic [erf_pkg::PIX_W-1:0]                 din,
    output logic [erf_pkg::TAPS-1:0][erf_pkg::PIX_W-1:0] win
);
    import erf_pkg::*;

    // Shift register: one slot per fetched byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= '0;
        end else if (cap) begin
            for (int k = 0; k < TAPS - 1; k++) win[k] <= win[k+1];
            win[TAPS-1] <= din;
        end
    end
endmodule

// File: rtl/erf_filt.sv
// Narrow edge filter datapath with one registered stage.
// On go it evaluates the window and registers the write mask and values.
// Mask bit 0..3 maps to p1, p0, q0, q1 (ascending address).
// Assumes the window is stable during the go cycle.
module erf_filt #(
    parameter int TW = 8
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       go,
    input  logic [erf_pkg::TAPS-1:0][erf_pkg::PIX_W-1:0]  win,
    input  logic [TW-1:0]                              elim,
    input  logic [TW-1:0]                              ilim,
    input  logic [TW-1:0]                              hlim,
    output logic                                       valid,
    output logic [erf_pkg::WWIN-1:0]                   mask,
    output logic [erf_pkg::WWIN-1:0][erf_pkg::PIX_W-1:0]  vals
);
    import erf_pkg::*;

    typedef logic signed [CW-1:0] sv_t;
    typedef logic        [CW-1:0] uv_t;

    function automatic uv_t absd(input sv_t a, input sv_t b);
        sv_t d;
        d = a - b;
        return (d < 0) ? uv_t'(-d) : uv_t'(d);
    endfunction

    function automatic sv_t sat8(input sv_t x);
        if (x < -sv_t'(128)) return -sv_t'(128);
        if (x > sv_t'(127))  return sv_t'(127);
        return x;
    endfunction

    function automatic sv_t cap127(input sv_t x);
        return (x > sv_t'(127)) ? sv_t'(127) : x;
    endfunction

    function automatic logic [PIX_W-1:0] clipu(input sv_t x);
        if (x < 0)           return '0;
        if (x > sv_t'(255))  return '1;
        return x[PIX_W-1:0];
    endfunction

    sv_t px [TAPS];
    uv_t e_u, i_u, h_u;
    logic fm, hev;
    sv_t f_base, f_all, f1, f2, fp;
    logic [WWIN-1:0]             mask_c;
    logic [WWIN-1:0][PIX_W-1:0]  vals_c;

    // Widen pixels and thresholds into the signed working width.
    always_comb begin
        for (int k = 0; k < TAPS; k++) px[k] = sv_t'({{(CW-PIX_W){1'b0}}, win[k]});
        e_u = uv_t'(elim);
        i_u = uv_t'(ilim);
        h_u = uv_t'(hlim);
    end

    // Decision: filter mask and high-variance test (px[3]=p0, px[4]=q0).
    always_comb begin
        fm = (absd(px[0], px[1]) <= i_u) && (absd(px[1], px[2]) <= i_u) &&
             (absd(px[2], px[3]) <= i_u) && (absd(px[5], px[4]) <= i_u) &&
             (absd(px[6], px[5]) <= i_u) && (absd(px[7], px[6]) <= i_u) &&
             ((absd(px[3], px[4]) << 1) + (absd(px[2], px[5]) >> 1) <= e_u);
        hev = (absd(px[2], px[3]) > h_u) || (absd(px[5], px[4]) > h_u);
    end

    // Arithmetic: saturated filter term and the adjusted pixels.
    always_comb begin
        f_base = hev ? sat8(px[2] - px[5]) : '0;
        f_all  = sat8(sv_t'(3) * (px[4] - px[3]) + f_base);
        f1     = cap127(f_all + sv_t'(4)) >>> 3;
        f2     = cap127(f_all + sv_t'(3)) >>> 3;
        fp     = (f1 + sv_t'(1)) >>> 1;
        vals_c[0] = hev ? win[2] : clipu(px[2] + fp);
        vals_c[1] = clipu(px[3] + f2);
        vals_c[2] = clipu(px[4] - f1);
        vals_c[3] = hev ? win[5] : clipu(px[5] - fp);
        if (!fm)      mask_c = 4'b0000;
        else if (hev) mask_c = 4'b0110;
        else          mask_c = 4'b1111;
    end

    // Output stage: hold the decision until the next go.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            mask  <= '0;
            vals  <= '0;
        end else begin
            valid <= go;
            if (go) begin
                mask <= mask_c;
                vals <= vals_c;
            end
        end
    end
endmodule

// File: rtl/edge_row_seq.sv
// Edge row sequencer: walks eight rows of one vertical boundary,
// fetching eight bytes per row, filtering them, and writing back only
// the enabled bytes in ascending order.
// Assumes a byte-wide synchronous memory with one-cycle read latency
// and a descriptor whose whole access range fits in the address space.
module edge_row_seq #(
    parameter int AW   = 16,
    parameter int TW   = 8,
    parameter int ROWS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          desc_valid,
    output logic          desc_ready,
    input  logic [AW-1:0] desc_offset,
    input  logic [TW-1:0] desc_elim,
    input  logic [TW-1:0] desc_ilim,
    input  logic [TW-1:0] desc_hlim,
    input  logic [AW-1:0] row_stride,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          done,
    output logic          err
);
    import erf_pkg::*;

    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int KW = $clog2(TAPS);
    localparam int XW = $clog2(TAPS + 1);
    localparam int IW = $clog2(WWIN);

    seq_state_t st, st_nx;
    logic [RW-1:0]  row;
    logic [KW-1:0]  rd_cnt;
    logic [XW-1:0]  rx_cnt;
    logic           cap_q, go_q;
    logic [WWIN-1:0] pend, low_bit;
    logic [IW-1:0]  wr_idx;
    logic [AW-1:0]  stride_q, base;
    logic [TW-1:0]  e_q, i_q, h_q;
    logic           accept, contract_ok, last_row, last_cap;
    logic           f_valid;
    logic [WWIN-1:0]             f_mask;
    logic [WWIN-1:0][PIX_W-1:0]  f_vals;
    logic [TAPS-1:0][PIX_W-1:0]  win;

    // Handshake and row bookkeeping terms.
    always_comb begin
        accept   = (st == S_IDLE) && desc_valid;
        last_row = (row == RW'(ROWS - 1));
        last_cap = cap_q && (rx_cnt == XW'(TAPS - 1));
    end

    erf_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .load(accept), .step((st == S_NEXT) && !last_row),
        .offset_in(desc_offset), .stride_in(row_stride), .stride_q(stride_q),
        .base(base), .contract_ok(contract_ok)
    );

    erf_win u_win (
        .clk(clk), .rst_n(rst_n), .cap(cap_q), .din(mem_rdata), .win(win)
    );

    erf_filt #(.TW(TW)) u_filt (
        .clk(clk), .rst_n(rst_n), .go(go_q), .win(win),
        .elim(e_q), .ilim(i_q), .hlim(h_q),
        .valid(f_valid), .mask(f_mask), .vals(f_vals)
    );

    // Lowest pending write slot (ascending address order).
    always_comb begin
        low_bit = pend & (~pend + WWIN'(1));
        wr_idx  = '0;
        for (int k = WWIN - 1; k >= 0; k--) if (pend[k]) wr_idx = IW'(k);
    end

    // Next-state logic.
    always_comb begin
        st_nx = st;
        case (st)
            S_IDLE:   if (desc_valid) st_nx = contract_ok ? S_READ : S_DONE;
            S_READ:   if (rd_cnt == KW'(TAPS - 1)) st_nx = S_FILTER;
            S_FILTER: if (f_valid) st_nx = (|f_mask) ? S_WRITE : S_NEXT;
            S_WRITE:  if ((pend & ~low_bit) == '0) st_nx = S_NEXT;
            S_NEXT:   st_nx = last_row ? S_DONE : S_READ;
            S_DONE:   st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Descriptor capture and contract flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stride_q <= '0;
            e_q <= '0; i_q <= '0; h_q <= '0;
            err <= 1'b0;
        end else if (accept) begin
            stride_q <= row_stride;
            e_q <= desc_elim; i_q <= desc_ilim; h_q <= desc_hlim;
            err <= !contract_ok;
        end
    end

    // Row counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                        row <= '0;
        else if (accept)                   row <= '0;
        else if (st == S_NEXT && !last_row) row <= row + RW'(1);
    end

    // Read issue counter and returned-byte tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            rx_cnt <= '0;
            cap_q  <= 1'b0;
            go_q   <= 1'b0;
        end else begin
            if (st == S_READ) rd_cnt <= rd_cnt + KW'(1);
            else              rd_cnt <= '0;
            cap_q <= (st == S_READ);
            go_q  <= last_cap;
            if (accept || st == S_NEXT) rx_cnt <= '0;
            else if (cap_q)             rx_cnt <= rx_cnt + XW'(1);
        end
    end

    // Pending write set for the current row.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pend <= '0;
        else if (st == S_FILTER && f_valid)  pend <= f_mask;
        else if (st == S_WRITE)              pend <= pend & ~low_bit;
    end

    // Memory port and status outputs.
    always_comb begin
        desc_ready = (st == S_IDLE);
        done       = (st == S_DONE);
        mem_rd_en  = (st == S_READ);
        mem_wr_en  = (st == S_WRITE);
        mem_wdata  = f_vals[wr_idx];
        if (st == S_WRITE) mem_addr = base - AW'(2) + AW'(wr_idx);
        else               mem_addr = base - AW'(HALF) + AW'(rd_cnt);
    end
endmodule

// File: rtl/erf_chk.sv
// Port-level protocol checker for the edge row sequencer.
// Assumes synchronous active-low reset; all properties are off during reset.
module erf_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          desc_ready,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic          err
);
    // R1: an idle sequencer is silent on memory and done.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> (!mem_rd_en && !mem_wr_en && !done));

    // R2: a refused descriptor causes no memory traffic.
    p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!mem_rd_en && !mem_wr_en));

    // R3: back-to-back reads step by one byte.
    p_read_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

    // R7: back-to-back writes rise in address.
    p_write_asc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && $past(mem_wr_en)) |-> (mem_addr > $past(mem_addr)));

    // R7: read and write are exclusive.
    p_rdwr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R8: done lasts one cycle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind edge_row_seq erf_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .desc_ready(desc_ready),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .done(done), .err(err)
);

// File: tb/sim_edge_row_seq.sv
`timescale 1ns/1ps
module sim_edge_row_seq;
    localparam int AW = 10;
    localparam int MSZ = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic desc_valid = 1'b0;
    logic desc_ready;
    logic [AW-1:0] desc_offset = '0, row_stride = '0;
    logic [7:0] desc_elim = '0, desc_ilim = '0, desc_hlim = '0;
    logic mem_rd_en, mem_wr_en, done, err;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = '0;

    logic fill_en = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [7:0] fill_val = '0;

    logic [7:0] mem [MSZ];
    logic [7:0] ref_mem [MSZ];

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // Expected per-cycle activity: kind 0 idle, 1 read, 2 write, 3 done.
    int    qk[$], qa[$], qd[$];
    string qt[$];

    always #4 clk = ~clk;

    edge_row_seq #(.AW(AW), .TW(8), .ROWS(8)) u0 (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_offset(desc_offset), .desc_elim(desc_elim), .desc_ilim(desc_ilim),
        .desc_hlim(desc_hlim), .row_stride(row_stride),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .err(err)
    );

    // Behavioural memory with one-cycle read latency.
    always @(posedge clk) begin
        if (fill_en) mem[fill_addr] <= fill_val;
        if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string tag, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    task automatic put(input int a, input int v);
        @(negedge clk);
        fill_en = 1'b1; fill_addr = AW'(a); fill_val = 8'(v);
        ref_mem[a] = 8'(v);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    function automatic int clampi(input int x, input int lo, input int hi);
        return (x < lo) ? lo : (x > hi) ? hi : x;
    endfunction

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    function automatic void push(input int k, input int a, input int d, input string t);
        qk.push_back(k); qa.push_back(a); qd.push_back(d); qt.push_back(t);
    endfunction

    // Reference model: builds the expected cycle stream and updates ref_mem.
    function automatic void plan_edge(input int off, input int s, input int e, input int i, input int h);
        int b, p3, p2, p1, p0, q0, q1, q2, q3, f, f1, f2, fp;
        bit fm, hev;
        if (off < 4 || s < 4) begin
            push(3, 0, 1, "R2");
            return;
        end
        for (int r = 0; r < 8; r++) begin
            b = off + r * s;
            for (int k = 0; k < 8; k++) push(1, b - 4 + k, 0, "R3");
            for (int k = 0; k < 3; k++) push(0, 0, 0, "R4");
            p3 = ref_mem[b-4]; p2 = ref_mem[b-3]; p1 = ref_mem[b-2]; p0 = ref_mem[b-1];
            q0 = ref_mem[b];   q1 = ref_mem[b+1]; q2 = ref_mem[b+2]; q3 = ref_mem[b+3];
            fm = iabs(p3-p2) <= i && iabs(p2-p1) <= i && iabs(p1-p0) <= i &&
                 iabs(q1-q0) <= i && iabs(q2-q1) <= i && iabs(q3-q2) <= i &&
                 iabs(p0-q0)*2 + (iabs(p1-q1) >>> 1) <= e;
            hev = iabs(p1-p0) > h || iabs(q1-q0) > h;
            if (fm) begin
                f  = hev ? clampi(p1 - q1, -128, 127) : 0;
                f  = clampi(3*(q0-p0) + f, -128, 127);
                f1 = clampi(f + 4, -1000, 127) >>> 3;
                f2 = clampi(f + 3, -1000, 127) >>> 3;
                fp = (f1 + 1) >>> 1;
                if (!hev) push(2, b-2, clampi(p1 + fp, 0, 255), "R6");
                push(2, b-1, clampi(p0 + f2, 0, 255), "R6");
                push(2, b,   clampi(q0 - f1, 0, 255), "R6");
                if (!hev) push(2, b+1, clampi(q1 - fp, 0, 255), "R6");
                if (!hev) ref_mem[b-2] = 8'(clampi(p1 + fp, 0, 255));
                ref_mem[b-1] = 8'(clampi(p0 + f2, 0, 255));
                ref_mem[b]   = 8'(clampi(q0 - f1, 0, 255));
                if (!hev) ref_mem[b+1] = 8'(clampi(q1 - fp, 0, 255));
            end
            push(0, 0, 0, "R5");
        end
        push(3, 0, 0, "R8");
    endfunction

    // Issue a descriptor and compare the port cycle by cycle against the model.
    task automatic run_edge(input int off, input int s, input int e, input int i, input int h);
        int k, a, d;
        string t;
        bit ok;
        plan_edge(off, s, e, i, h);
        @(negedge clk);
        check(desc_ready === 1'b1, "R1", $sformatf("ready before descriptor got %b exp 1", desc_ready));
        desc_valid = 1'b1; desc_offset = AW'(off); row_stride = AW'(s);
        desc_elim = 8'(e); desc_ilim = 8'(i); desc_hlim = 8'(h);
        @(negedge clk);
        desc_valid = 1'b0;
        while (qk.size() > 0) begin
            k = qk.pop_front(); a = qa.pop_front(); d = qd.pop_front(); t = qt.pop_front();
            case (k)
                0: ok = !mem_rd_en && !mem_wr_en && !done;
                1: ok = mem_rd_en && !mem_wr_en && !done && int'(mem_addr) == a;
                2: ok = mem_wr_en && !mem_rd_en && !done && int'(mem_addr) == a && int'(mem_wdata) == d;
                default: ok = done && !mem_rd_en && !mem_wr_en && int'(err) == d;
            endcase
            ok = ok && (desc_ready === 1'b0);
            check(ok, t, $sformatf("kind %0d got rd=%b wr=%b addr=%0d wd=%0d done=%b err=%b rdy=%b exp addr=%0d data=%0d",
                  k, mem_rd_en, mem_wr_en, mem_addr, mem_wdata, done, err, desc_ready, a, d));
            @(negedge clk);
        end
        check(desc_ready && !done && !mem_rd_en && !mem_wr_en, "R8",
              $sformatf("after edge got ready=%b done=%b exp ready=1 done=0", desc_ready, done));
    endtask

    // Fill an edge region; mode picks the pixel pattern.
    task automatic fill_edge(input int off, input int s, input int mode);
        int v;
        for (int r = 0; r < 8; r++)
            for (int k = 0; k < 8; k++) begin
                case (mode)
                    0: v = (k < 4) ? 100 + r : 104 + r;                   // smooth step
                    1: v = (k == 2) ? 104 : (k < 4) ? 100 : 102;          // high variance
                    2: v = (k < 4) ? 50 : 200;                            // hard edge
                    3: v = (k < 4) ? 20 : 120;                            // saturate up
                    4: v = (k < 4) ? 240 : 140;                           // saturate down
                    default: v = 120 + $urandom_range(0, 12) + ((k < 4) ? 0 : $urandom_range(0, 10));
                endcase
                put(off + r * s - 4 + k, v);
            end
    endtask

    task automatic idle_check(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            check(!mem_rd_en && !mem_wr_en && !done && desc_ready, "R1",
                  $sformatf("idle got rd=%b wr=%b done=%b ready=%b exp 0 0 0 1", mem_rd_en, mem_wr_en, done, desc_ready));
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        int diffs, first;
        for (int a = 0; a < MSZ; a++) begin
            mem[a] = 8'((a * 7 + 3) & 255);
            ref_mem[a] = mem[a];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(desc_ready && !done && !err && !mem_rd_en && !mem_wr_en, "R1",
              $sformatf("reset state got ready=%b done=%b err=%b exp 1 0 0", desc_ready, done, err));
        idle_check(4);

        // R5/R6: low variance, four writes per row.
        fill_edge(20, 16, 0);   run_edge(20, 16, 20, 10, 10);
        // R5: high variance, two writes per row.
        fill_edge(200, 12, 1);  run_edge(200, 12, 20, 10, 2);
        // R5: mask fails, no writes.
        fill_edge(320, 10, 2);  run_edge(320, 10, 20, 10, 10);
        // R6: positive saturation.
        fill_edge(420, 9, 3);   run_edge(420, 9, 255, 255, 255);
        // R6: negative saturation.
        fill_edge(520, 9, 4);   run_edge(520, 9, 255, 255, 255);
        // R2: offset below limit, then stride below limit.
        run_edge(3, 8, 20, 10, 10);
        idle_check(2);
        run_edge(600, 3, 20, 10, 10);
        // R2/R3: minimum legal offset and stride, overlapping reads.
        fill_edge(4, 4, 0);     run_edge(4, 4, 30, 12, 1);
        // R4/R6: noisy edges with mixed decisions.
        for (int n = 0; n < 6; n++) begin
            fill_edge(640 + n * 4, 4 + n, 5);
            run_edge(640 + n * 4, 4 + n, 24, 8, 3);
        end

        // R9: whole memory matches the reference image.
        diffs = 0; first = -1;
        for (int a = 0; a < MSZ; a++)
            if (mem[a] !== ref_mem[a]) begin
                diffs++;
                if (first < 0) first = a;
            end
        check(diffs == 0, "R9", $sformatf("memory image got %0d differing bytes (first at %0d) exp 0", diffs, first));
        finish_run();
    end
endmodule